// File: doc/BRIEF.md
# Boot-Block Lock Protection Unit

This unit guards the alteration of a 2M-word flash array divided into seventy-one blocks of uneven size. Sixty-three 32K-word main blocks fill the lower part of the address space. The topmost 32K words are split into eight 4K-word blocks: six parameter blocks, with the two boot blocks at the very top. The unit keeps one lock bit per block and a single permanent lock bit. When a request is strobed, it maps the address onto a block index and decides whether the request may proceed.

Requests are program, block erase, chip erase, set-one-lock, set-permanent-lock and clear-all-locks. An active-low write-protect pin works together with the lock bits. While the pin is high and the permanent bit is clear, the locks on the two boot blocks are overridden. The permanent bit freezes every block lock bit and removes the boot override. Granted lock operations update the internal state on the same clock edge that registers the response, so the next request already sees the new state.

Top module: `lock_guard`

## Requirements
- R1: The block index is computed from the word address. When bits 20..15 are not all ones, the index equals those bits (0..62). Otherwise the index is 63 plus bits 14..12: 63..68 are parameter blocks and 69..70 are boot blocks.
- R2: Every strobe yields a response one clock later. The response is a single-cycle `resp_valid` pulse in which exactly one of `resp_grant` and `resp_deny` is high. Outside that pulse, grant, deny and the error flag are low.
- R3: A program request (op 0) or a block erase request (op 1) that targets a block whose lock is in force is denied with `resp_lock_err` high. If the block's lock is not in force, the request is granted with the error flag low.
- R4: With `wp_n` high and the permanent bit clear, the lock bits of blocks 69 and 70 are not enforced. With `wp_n` low, every lock bit is enforced. Parameter and main block locks never depend on `wp_n`.
- R5: While the permanent bit is set, the boot override is removed. Set-lock (op 3) and clear-locks (op 5) are then denied with the error flag high, and no block lock bit changes.
- R6: A granted set-lock sets only the lock bit of the addressed block.
- R7: A granted clear-locks clears all seventy-one block lock bits at once.
- R8: Chip erase (op 2) is granted only when no block lock bit is set, whatever the state of `wp_n`. Otherwise it is denied with the error flag high.
- R9: Set-permanent (op 4) is always granted and sets the permanent bit. Only reset clears that bit.
- R10: Op codes 6 and 7 are denied with the error flag low and change no state.
- R11: After reset, all lock bits and the permanent bit are clear, and all response outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears all lock state |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_op | input | 3 | Operation code (0 program, 1 block erase, 2 chip erase, 3 set lock, 4 set permanent, 5 clear locks) |
| req_addr | input | 9 | Word address bits 20..12 (the bits that select a block) |
| wp_n | input | 1 | Write-protect pin, active low |
| resp_valid | output | 1 | Response pulse, one cycle after the strobe |
| resp_grant | output | 1 | Request allowed |
| resp_deny | output | 1 | Request refused |
| resp_lock_err | output | 1 | Refusal caused by lock protection |
| resp_block | output | 7 | Index of the addressed block |

## Verification
Each response, together with the block index it carries, appears on the rising edge after the strobe edge. A lock state change from a granted request becomes visible to the next request. The bench drives each request on a falling edge and samples the outputs on the following falling edge, which lies half a cycle after the registering edge. One cycle later it confirms that the pulse has ended. The effect of a lock operation, or the absence of one, is always checked through the grant or deny of a later program, erase or chip erase request.

// File: rtl/lock_guard.sv
`timescale 1ns/1ps
module lock_guard #(
  parameter int ADDR_W  = 21,
  parameter int MAIN_W  = 15,
  parameter int SMALL_W = 12,
  parameter int N_BOOT  = 2,
  parameter int OP_W    = 3,
  localparam int TOP_W   = ADDR_W - MAIN_W,
  localparam int SUB_W   = MAIN_W - SMALL_W,
  localparam int N_SMALL = 2 ** SUB_W,
  localparam int N_MAIN  = 2 ** TOP_W - 1,
  localparam int N_BLK   = N_MAIN + N_SMALL,
  localparam int IDX_W   = $clog2(N_BLK)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic [OP_W-1:0]           req_op,
  input  logic [ADDR_W-1:SMALL_W]   req_addr,
  input  logic                      wp_n,
  output logic                      resp_valid,
  output logic                      resp_grant,
  output logic                      resp_deny,
  output logic                      resp_lock_err,
  output logic [IDX_W-1:0]          resp_block
);
  localparam int N_PARAM = N_SMALL - N_BOOT;

  localparam logic [OP_W-1:0] OP_PROG  = OP_W'(0);
  localparam logic [OP_W-1:0] OP_BERS  = OP_W'(1);
  localparam logic [OP_W-1:0] OP_CERS  = OP_W'(2);
  localparam logic [OP_W-1:0] OP_SETLK = OP_W'(3);
  localparam logic [OP_W-1:0] OP_PERM  = OP_W'(4);
  localparam logic [OP_W-1:0] OP_CLRLK = OP_W'(5);

  logic [N_BLK-1:0] lock_q;
  logic             perm_q;

  logic [TOP_W-1:0] top_f;
  logic [SUB_W-1:0] sub_f;
  logic             in_small;
  logic             is_boot;
  logic [IDX_W-1:0] blk_idx;
  logic             blk_locked;
  logic             any_lock;
  logic             grant;
  logic             lerr;

  assign top_f    = req_addr[ADDR_W-1:MAIN_W];
  assign sub_f    = req_addr[MAIN_W-1:SMALL_W];
  assign in_small = &top_f;
  assign is_boot  = in_small && (sub_f >= SUB_W'(N_PARAM));
  assign blk_idx  = in_small ? IDX_W'(N_MAIN) + IDX_W'(sub_f) : IDX_W'(top_f);

  assign blk_locked = lock_q[blk_idx] && !(wp_n && is_boot && !perm_q);
  assign any_lock   = |lock_q;

  always_comb begin
    grant = 1'b0;
    lerr  = 1'b0;
    case (req_op)
      OP_PROG, OP_BERS: begin
        grant = !blk_locked;
        lerr  = blk_locked;
      end
      OP_CERS: begin
        grant = !any_lock;
        lerr  = any_lock;
      end
      OP_SETLK, OP_CLRLK: begin
        grant = !perm_q;
        lerr  = perm_q;
      end
      OP_PERM: grant = 1'b1;
      default: ;
    endcase
  end

  for (genvar b = 0; b < N_BLK; b++) begin : g_lock
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        lock_q[b] <= 1'b0;
      else if (req_valid && grant) begin
        if (req_op == OP_CLRLK)
          lock_q[b] <= 1'b0;
        else if (req_op == OP_SETLK && blk_idx == IDX_W'(b))
          lock_q[b] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      perm_q <= 1'b0;
    else if (req_valid && req_op == OP_PERM)
      perm_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid    <= 1'b0;
      resp_grant    <= 1'b0;
      resp_deny     <= 1'b0;
      resp_lock_err <= 1'b0;
      resp_block    <= '0;
    end else begin
      resp_valid    <= req_valid;
      resp_grant    <= req_valid && grant;
      resp_deny     <= req_valid && !grant;
      resp_lock_err <= req_valid && lerr;
      if (req_valid)
        resp_block <= blk_idx;
    end
  end
endmodule

// File: rtl/lock_guard_chk.sv
`timescale 1ns/1ps
module lock_guard_chk #(
  parameter int ADDR_W  = 21,
  parameter int MAIN_W  = 15,
  parameter int SMALL_W = 12,
  parameter int OP_W    = 3,
  parameter int N_BLK   = 71,
  parameter int IDX_W   = 7
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_valid,
  input logic [OP_W-1:0]         req_op,
  input logic [ADDR_W-1:SMALL_W] req_addr,
  input logic                    resp_valid,
  input logic                    resp_grant,
  input logic                    resp_deny,
  input logic                    resp_lock_err,
  input logic [IDX_W-1:0]        resp_block,
  input logic [N_BLK-1:0]        lock_q,
  input logic                    perm_q
);
  localparam int TOP_W = ADDR_W - MAIN_W;
  localparam logic [OP_W-1:0] C_CERS  = OP_W'(2);
  localparam logic [OP_W-1:0] C_SETLK = OP_W'(3);
  localparam logic [OP_W-1:0] C_PERM  = OP_W'(4);
  localparam logic [OP_W-1:0] C_CLRLK = OP_W'(5);

  assert_resp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);
  assert_resp_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid && !resp_grant && !resp_deny && !resp_lock_err);
  assert_one_verdict_R2: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (resp_grant ^ resp_deny));
  assert_grant_no_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
    resp_grant |-> !resp_lock_err);
  assert_main_index_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !(&req_addr[ADDR_W-1:MAIN_W]) |=>
      resp_block == IDX_W'($past(req_addr[ADDR_W-1:MAIN_W])));
  assert_frozen_locks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    perm_q |=> $stable(lock_q));
  assert_frozen_deny_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && perm_q && (req_op == C_SETLK || req_op == C_CLRLK) |=> resp_deny && resp_lock_err);
  assert_chip_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_op == C_CERS && (|lock_q) |=> resp_deny && resp_lock_err);
  assert_perm_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    perm_q |=> perm_q);
  assert_perm_granted_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_op == C_PERM |=> resp_grant && perm_q);

  logic unused_top;
  assign unused_top = ^TOP_W;
endmodule

bind lock_guard lock_guard_chk #(
  .ADDR_W(ADDR_W), .MAIN_W(MAIN_W), .SMALL_W(SMALL_W), .OP_W(OP_W),
  .N_BLK(N_BLK), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .req_addr(req_addr), .resp_valid(resp_valid), .resp_grant(resp_grant),
  .resp_deny(resp_deny), .resp_lock_err(resp_lock_err),
  .resp_block(resp_block), .lock_q(lock_q), .perm_q(perm_q)
);

// File: tb/test_lock_guard.sv
`timescale 1ns/1ps
module test_lock_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = '0;
  logic [20:12] req_addr = '0;
  logic        wp_n = 1'b0;
  logic        resp_valid, resp_grant, resp_deny, resp_lock_err;
  logic [6:0]  resp_block;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  lock_guard i_lock_guard (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .wp_n(wp_n), .resp_valid(resp_valid),
    .resp_grant(resp_grant), .resp_deny(resp_deny),
    .resp_lock_err(resp_lock_err), .resp_block(resp_block)
  );

  localparam logic [2:0] PROG = 3'd0, BERS = 3'd1, CERS = 3'd2,
                         SETLK = 3'd3, PERM = 3'd4, CLRLK = 3'd5;

  function automatic logic [20:0] mainb(input int b);
    return 21'(b) << 15;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic req(input logic [2:0] op, input logic [20:0] addr, input logic wp,
                     input logic eg, input logic ee, input int eb, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = addr[20:12]; wp_n = wp;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " valid"}, resp_valid, 1);
    chk({tag, " grant"}, resp_grant, eg);
    chk({tag, " deny"},  resp_deny, !eg);
    chk({tag, " err"},   resp_lock_err, ee);
    chk({tag, " block"}, resp_block, eb);
  endtask

  task automatic t_reset;
    chk("R11 valid", resp_valid, 0);
    chk("R11 grant", resp_grant, 0);
    chk("R11 deny",  resp_deny, 0);
    chk("R11 err",   resp_lock_err, 0);
    chk("R11 block", resp_block, 0);
    req(CERS, mainb(0), 1'b0, 1'b1, 1'b0, 0, "R11 no locks after reset");
  endtask

  task automatic t_map;
    req(PROG, 21'h000000, 1'b0, 1'b1, 1'b0, 0,  "R1 block0");
    req(PROG, 21'h1E7FFF, 1'b0, 1'b1, 1'b0, 60, "R1 block60");
    req(PROG, 21'h1F7FFF, 1'b0, 1'b1, 1'b0, 62, "R1 last main");
    req(PROG, 21'h1F8000, 1'b0, 1'b1, 1'b0, 63, "R1 first param");
    req(PROG, 21'h1FA123, 1'b0, 1'b1, 1'b0, 65, "R1 param65");
    req(PROG, 21'h1FDFFF, 1'b0, 1'b1, 1'b0, 68, "R1 last param");
    req(PROG, 21'h1FE000, 1'b0, 1'b1, 1'b0, 69, "R1 first boot");
    req(PROG, 21'h1FFFFF, 1'b0, 1'b1, 1'b0, 70, "R1 top boot");
  endtask

  task automatic t_pulse;
    req(BERS, mainb(3), 1'b0, 1'b1, 1'b0, 3, "R2 erase");
    @(negedge clk);
    chk("R2 pulse end valid", resp_valid, 0);
    chk("R2 pulse end grant", resp_grant, 0);
    chk("R2 pulse end deny",  resp_deny, 0);
  endtask

  task automatic t_lock;
    req(SETLK, mainb(5), 1'b0, 1'b1, 1'b0, 5, "R6 set lock 5");
    req(PROG,  mainb(5), 1'b0, 1'b0, 1'b1, 5, "R3 program locked");
    req(BERS,  mainb(5) + 21'h1234, 1'b0, 1'b0, 1'b1, 5, "R3 erase locked");
    req(PROG,  mainb(6), 1'b0, 1'b1, 1'b0, 6, "R6 neighbour unlocked");
    req(PROG,  mainb(4), 1'b1, 1'b1, 1'b0, 4, "R6 other neighbour");
    req(PROG,  mainb(5), 1'b1, 1'b0, 1'b1, 5, "R4 main lock ignores wp");
  endtask

  task automatic t_wp;
    req(SETLK, 21'h1FF000, 1'b0, 1'b1, 1'b0, 70, "R6 set boot70");
    req(SETLK, 21'h1F8000, 1'b0, 1'b1, 1'b0, 63, "R6 set param63");
    req(PROG,  21'h1FF000, 1'b1, 1'b1, 1'b0, 70, "R4 boot override wp high");
    req(PROG,  21'h1FF000, 1'b0, 1'b0, 1'b1, 70, "R4 boot enforced wp low");
    req(PROG,  21'h1F8000, 1'b1, 1'b0, 1'b1, 63, "R4 param not overridden");
    req(PROG,  21'h1FE000, 1'b0, 1'b1, 1'b0, 69, "R4 boot69 unlocked");
  endtask

  task automatic t_chip;
    req(CERS, mainb(0), 1'b1, 1'b0, 1'b1, 0, "R8 chip erase wp high locked");
    req(CERS, mainb(0), 1'b0, 1'b0, 1'b1, 0, "R8 chip erase wp low locked");
  endtask

  task automatic t_clear;
    req(CLRLK, mainb(9), 1'b0, 1'b1, 1'b0, 9, "R7 clear locks");
    req(PROG,  mainb(5), 1'b0, 1'b1, 1'b0, 5, "R7 block5 cleared");
    req(PROG,  21'h1F8000, 1'b0, 1'b1, 1'b0, 63, "R7 param63 cleared");
    req(PROG,  21'h1FF000, 1'b0, 1'b1, 1'b0, 70, "R7 boot70 cleared");
    req(CERS,  mainb(0), 1'b0, 1'b1, 1'b0, 0, "R8 chip erase no locks");
  endtask

  task automatic t_invalid;
    req(SETLK, mainb(7), 1'b0, 1'b1, 1'b0, 7, "R6 set lock 7");
    req(3'd7,  mainb(7), 1'b0, 1'b0, 1'b0, 7, "R10 op7 denied");
    req(PROG,  mainb(7), 1'b0, 1'b0, 1'b1, 7, "R10 lock7 kept");
    req(3'd6,  mainb(8), 1'b0, 1'b0, 1'b0, 8, "R10 op6 denied");
    req(PROG,  mainb(8), 1'b0, 1'b1, 1'b0, 8, "R10 block8 not locked");
    req(CLRLK, mainb(0), 1'b0, 1'b1, 1'b0, 0, "R7 clear again");
    req(CERS,  mainb(0), 1'b0, 1'b1, 1'b0, 0, "R10 no permanent set");
  endtask

  task automatic t_perm;
    req(SETLK, 21'h1FF000, 1'b0, 1'b1, 1'b0, 70, "R6 set boot70");
    req(SETLK, mainb(10),  1'b0, 1'b1, 1'b0, 10, "R6 set lock 10");
    req(PERM,  mainb(0),   1'b0, 1'b1, 1'b0, 0,  "R9 set permanent");
    req(PROG,  21'h1FF000, 1'b1, 1'b0, 1'b1, 70, "R5 boot override removed");
    req(SETLK, mainb(20),  1'b0, 1'b0, 1'b1, 20, "R5 set lock refused");
    req(PROG,  mainb(20),  1'b0, 1'b1, 1'b0, 20, "R5 lock20 unchanged");
    req(CLRLK, mainb(0),   1'b0, 1'b0, 1'b1, 0,  "R5 clear refused");
    req(PROG,  mainb(10),  1'b0, 1'b0, 1'b1, 10, "R5 lock10 kept");
    req(PERM,  mainb(1),   1'b1, 1'b1, 1'b0, 1,  "R9 permanent again");
    req(BERS,  mainb(10),  1'b1, 1'b0, 1'b1, 10, "R9 permanent persists");
    req(CERS,  mainb(0),   1'b0, 1'b0, 1'b1, 0,  "R8 chip erase locked");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_map;
    t_pulse;
    t_lock;
    t_wp;
    t_chip;
    t_clear;
    t_invalid;
    t_perm;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule